// File: doc/BRIEF.md
# Multi-CPU Auto-Masking Interrupt Controller

This block gathers level-sensitive hardware interrupt lines from a small multiprocessor's peripherals and hands them to a configurable number of CPUs. Every line has a mask bit, a software trigger bit that is ORed onto the line, and a per-line set of CPUs that may receive it. Every CPU also owns two inter-processor interrupt (IPI) flags that any CPU can raise.

Software services interrupts by reading one event register. The read returns the most urgent source routed to the reading CPU and acknowledges it in the same access. A hardware source is acknowledged by setting its mask bit, and an IPI by clearing its flag. Priority is fixed: IPIs come first, slot 0 before slot 1. Among hardware sources the lowest number wins. A single register window resolves to whichever CPU performs the access, and explicit windows reach each CPU's registers directly. One request output per CPU is high while that CPU has anything deliverable.

The register bus accepts one access per cycle. Read data and a response strobe appear one clock after the request.

Top module: `irqc_top`

## Requirements
- R1: A hardware source is pending only while its input line is high (or its software trigger is set). When the line drops, that source no longer raises the request output or appears in the event register.
- R2: A source whose mask bit is set is never delivered to any CPU.
- R3: The software trigger bits are ORed with the hardware lines. They are set by a write-1 to byte offset 0x040 and cleared by a write-1 to 0x060 (32 lines per word, word index in address bits [4:2]).
- R4: A source reaches CPU c only when bit c of its affinity register is set. The affinity register for line i is at 0x800 + 4*i, and its reset value is 1 (CPU 0 only).
- R5: Event word layout: bits [17:16] hold the type (0 = none, 1 = hardware, 2 = IPI) and bits [15:0] hold the source number. Reading a hardware event sets that source's mask bit, so the source is not returned again until it is unmasked.
- R6: Among eligible hardware sources, the event register returns the lowest-numbered one.
- R7: IPIs are returned before hardware sources, slot 0 before slot 1. Reading an IPI event clears that flag. A write to a view's IPI-send offset (+0x04) raises slot 0 on CPU c for wdata bit c, and slot 1 on CPU c for wdata bit 16+c.
- R8: An event read with nothing deliverable returns zero and changes no state.
- R9: The window at 0x100 addresses the accessing CPU. The window at 0x200 + 0x100*c addresses CPU c. Each window holds the event register at +0x00, IPI-send at +0x04, IPI-clear (write-1-to-clear) at +0x08 and IPI-pending readback at +0x0C.
- R10: Masks are set by a write-1 to 0x000 and cleared by a write-1 to 0x020; both offsets read back the mask. Raw hardware levels read at 0x080. After reset all masks are set, and all triggers and IPIs are clear.
- R11: Request output c is high exactly when CPU c has an IPI flag set or an eligible hardware source.
- R12: Every accepted access produces the response strobe one clock later, together with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_irq_i | input | N_IRQ | Level-sensitive hardware interrupt lines |
| bus_valid_i | input | 1 | Register access request |
| bus_ready_o | output | 1 | Access accepted (always high) |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_cpu_i | input | 4 | Identifier of the accessing CPU |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Response strobe, one cycle after a request |
| bus_rdata_o | output | 32 | Read data |
| irq_o | output | N_CPU | Interrupt request per CPU |

## Verification
A table of vectors drives the lines, the triggers and the unmask pattern. The vectors cover a single hardware source, a trigger-only source, a high source hidden behind a mask, a trigger below several hardware lines, a fully masked set and an all-high set with one opening. Each vector's event value shows whether the OR, the mask gate and the lowest-first order are working. Directed sequences then separate the routing cases: a source steered to the second CPU, the banked window read from each CPU, and an IPI raised on top of a pending hardware source, which shows the precedence. Repeat reads after each acknowledge show whether the acknowledge side effects landed: a mask set, a flag cleared, or nothing changed on an empty read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int CPU_IDW = 4;

    localparam logic [1:0] EV_NONE = 2'd0;
    localparam logic [1:0] EV_HW   = 2'd1;
    localparam logic [1:0] EV_IPI  = 2'd2;

    typedef enum logic [3:0] {
        K_NONE,
        K_MASK_SET,
        K_MASK_CLR,
        K_SWT_SET,
        K_SWT_CLR,
        K_HW_LVL,
        K_AFF,
        K_EVENT,
        K_IPI_SEND,
        K_IPI_CLR,
        K_IPI_PEND
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e            kind;
        logic [2:0]           word;
        logic [7:0]           irq;
        logic [CPU_IDW-1:0]   cpu;
    } reg_cmd_t;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int N_CPU = 2
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [CPU_IDW-1:0] cpu_i,
    output reg_cmd_t           cmd_o
);
    logic [3:0]         page;
    logic [CPU_IDW-1:0] view_cpu;
    logic [1:0]         unused_lsb;

    assign page       = addr_i[11:8];
    assign unused_lsb = addr_i[1:0];

    always_comb begin
        view_cpu   = (page == 4'd1) ? cpu_i : CPU_IDW'(page - 4'd2);
        cmd_o      = '0;
        cmd_o.kind = K_NONE;
        cmd_o.word = addr_i[4:2];
        cmd_o.irq  = addr_i[9:2];
        cmd_o.cpu  = view_cpu;
        if (addr_i[11:10] == 2'b10) begin
            cmd_o.kind = K_AFF;
        end else if (page == 4'd0) begin
            case (addr_i[7:5])
                3'd0:    cmd_o.kind = K_MASK_SET;
                3'd1:    cmd_o.kind = K_MASK_CLR;
                3'd2:    cmd_o.kind = K_SWT_SET;
                3'd3:    cmd_o.kind = K_SWT_CLR;
                3'd4:    cmd_o.kind = K_HW_LVL;
                default: cmd_o.kind = K_NONE;
            endcase
        end else if (page <= 4'd7 && int'(view_cpu) < N_CPU) begin
            case (addr_i[7:2])
                6'd0:    cmd_o.kind = K_EVENT;
                6'd1:    cmd_o.kind = K_IPI_SEND;
                6'd2:    cmd_o.kind = K_IPI_CLR;
                6'd3:    cmd_o.kind = K_IPI_PEND;
                default: cmd_o.kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int N_IRQ = 32,
    parameter int N_CPU = 2
) (
    input  logic [N_IRQ-1:0]             hw_i,
    input  logic [N_IRQ-1:0]             swt_i,
    input  logic [N_IRQ-1:0]             mask_i,
    input  logic [N_IRQ-1:0][N_CPU-1:0]  aff_i,
    output logic [N_CPU-1:0][N_IRQ-1:0]  elig_o
);
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        for (genvar i = 0; i < N_IRQ; i++) begin : g_line
            assign elig_o[c][i] = (hw_i[i] | swt_i[i]) & ~mask_i[i] & aff_i[i][c];
        end
    end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int N    = 32,
    parameter int IDXW = $clog2(N)
) (
    input  logic [N-1:0]    req_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDXW'(i);
            end
        end
    end

    always_comb begin
        if (found_o) begin
            // R6
            lowest_first_chk: assert ((req_i & ((N'(1) << idx_o) - N'(1))) == '0);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int N_IRQ = 32,
    parameter int N_CPU = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IRQ-1:0]     hw_irq_i,
    input  logic                 bus_valid_i,
    output logic                 bus_ready_o,
    input  logic                 bus_write_i,
    input  logic [CPU_IDW-1:0]   bus_cpu_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic                 bus_rvalid_o,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic [N_CPU-1:0]     irq_o
);
    localparam int IDXW = $clog2(N_IRQ);

    typedef struct packed {
        logic [N_IRQ-1:0]            mask;
        logic [N_IRQ-1:0]            swt;
        logic [N_IRQ-1:0][N_CPU-1:0] aff;
        logic [N_CPU-1:0][1:0]       ipi;
        logic                        rvalid;
        logic [DATA_W-1:0]           rdata;
    } state_t;

    state_t q, d;

    function automatic state_t reset_state();
        state_t s;
        s      = '0;
        s.mask = '1;
        for (int i = 0; i < N_IRQ; i++) s.aff[i] = N_CPU'(1);
        return s;
    endfunction

    function automatic logic [N_IRQ-1:0] spread(input logic [DATA_W-1:0] w,
                                                input logic [2:0] idx);
        logic [N_IRQ-1:0] v;
        for (int i = 0; i < N_IRQ; i++)
            v[i] = (i / 32 == int'(idx)) ? w[i % 32] : 1'b0;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] gather(input logic [N_IRQ-1:0] v,
                                                 input logic [2:0] idx);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < N_IRQ; i++)
            if (i / 32 == int'(idx)) w[i % 32] = v[i];
        return w;
    endfunction

    reg_cmd_t                   cmd;
    logic [N_CPU-1:0][N_IRQ-1:0] elig;
    logic [N_CPU-1:0]            hw_found;
    logic [N_CPU-1:0][IDXW-1:0]  hw_idx;
    logic [N_CPU-1:0][DATA_W-1:0] ev_word;
    logic [DATA_W-1:0]           sel_ev;
    logic [1:0]                  sel_ipi;
    logic [IDXW-1:0]             ev_idx;
    logic [N_IRQ-1:0]            wvec;
    logic                        evt_rd;

    irqc_decode #(.N_CPU(N_CPU)) u_decode (
        .addr_i (bus_addr_i),
        .cpu_i  (bus_cpu_i),
        .cmd_o  (cmd)
    );

    irqc_route #(.N_IRQ(N_IRQ), .N_CPU(N_CPU)) u_route (
        .hw_i   (hw_irq_i),
        .swt_i  (q.swt),
        .mask_i (q.mask),
        .aff_i  (q.aff),
        .elig_o (elig)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        logic [DATA_W-1:0] ev;

        irqc_prio #(.N(N_IRQ), .IDXW(IDXW)) u_prio (
            .req_i   (elig[c]),
            .found_o (hw_found[c]),
            .idx_o   (hw_idx[c])
        );

        always_comb begin
            ev = '0;
            if (q.ipi[c][0]) begin
                ev[17:16] = EV_IPI;
            end else if (q.ipi[c][1]) begin
                ev[17:16] = EV_IPI;
                ev[15:0]  = 16'd1;
            end else if (hw_found[c]) begin
                ev[17:16] = EV_HW;
                ev[15:0]  = 16'(hw_idx[c]);
            end
        end

        assign ev_word[c] = ev;
        assign irq_o[c]   = (|elig[c]) | (|q.ipi[c]);

        // R2
        masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_found[c] |-> !q.mask[hw_idx[c]]);
    end

    always_comb begin
        sel_ev  = '0;
        sel_ipi = '0;
        for (int c = 0; c < N_CPU; c++) begin
            if (cmd.cpu == CPU_IDW'(c)) begin
                sel_ev  = ev_word[c];
                sel_ipi = q.ipi[c];
            end
        end
    end

    assign ev_idx = sel_ev[IDXW-1:0];
    assign wvec   = spread(bus_wdata_i, cmd.word);
    assign evt_rd = bus_valid_i && !bus_write_i && (cmd.kind == K_EVENT);

    always_comb begin
        d        = q;
        d.rvalid = bus_valid_i;
        d.rdata  = '0;
        if (bus_valid_i) begin
            case (cmd.kind)
                K_MASK_SET: begin
                    if (bus_write_i) d.mask = q.mask | wvec;
                    else             d.rdata = gather(q.mask, cmd.word);
                end
                K_MASK_CLR: begin
                    if (bus_write_i) d.mask = q.mask & ~wvec;
                    else             d.rdata = gather(q.mask, cmd.word);
                end
                K_SWT_SET: begin
                    if (bus_write_i) d.swt = q.swt | wvec;
                    else             d.rdata = gather(q.swt, cmd.word);
                end
                K_SWT_CLR: begin
                    if (bus_write_i) d.swt = q.swt & ~wvec;
                    else             d.rdata = gather(q.swt, cmd.word);
                end
                K_HW_LVL: begin
                    if (!bus_write_i) d.rdata = gather(hw_irq_i, cmd.word);
                end
                K_AFF: begin
                    for (int i = 0; i < N_IRQ; i++) begin
                        if (cmd.irq == 8'(i)) begin
                            if (bus_write_i) d.aff[i] = bus_wdata_i[N_CPU-1:0];
                            else             d.rdata[N_CPU-1:0] = q.aff[i];
                        end
                    end
                end
                K_EVENT: begin
                    if (!bus_write_i) begin
                        d.rdata = sel_ev;
                        for (int c = 0; c < N_CPU; c++) begin
                            if (cmd.cpu == CPU_IDW'(c)) begin
                                if (sel_ev[17:16] == EV_HW)  d.mask[ev_idx] = 1'b1;
                                if (sel_ev[17:16] == EV_IPI) d.ipi[c][sel_ev[0]] = 1'b0;
                            end
                        end
                    end
                end
                K_IPI_SEND: begin
                    if (bus_write_i) begin
                        for (int c = 0; c < N_CPU; c++) begin
                            if (bus_wdata_i[c])      d.ipi[c][0] = 1'b1;
                            if (bus_wdata_i[16 + c]) d.ipi[c][1] = 1'b1;
                        end
                    end
                end
                K_IPI_CLR: begin
                    if (bus_write_i) begin
                        for (int c = 0; c < N_CPU; c++)
                            if (cmd.cpu == CPU_IDW'(c))
                                d.ipi[c] = q.ipi[c] & ~bus_wdata_i[1:0];
                    end
                end
                K_IPI_PEND: begin
                    if (!bus_write_i) d.rdata[1:0] = sel_ipi;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= reset_state();
        else        q <= d;
    end

    assign bus_ready_o  = 1'b1;
    assign bus_rvalid_o = q.rvalid;
    assign bus_rdata_o  = q.rdata;

    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_i |=> bus_rvalid_o);

    // R5
    auto_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && sel_ev[17:16] == EV_HW) |=> q.mask[$past(ev_idx)]);

    // R7
    ipi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && (|sel_ipi)) |-> (sel_ev[17:16] == EV_IPI));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_rd && sel_ev == '0) |=> ($stable(q.mask) && $stable(q.ipi) && bus_rdata_o == '0));
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw = '0;
    logic        bus_valid = 1'b0;
    logic        bus_ready;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_cpu = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irqc_top #(.N_IRQ(32), .N_CPU(2)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_irq_i     (hw),
        .bus_valid_i  (bus_valid),
        .bus_ready_o  (bus_ready),
        .bus_write_i  (bus_write),
        .bus_cpu_i    (bus_cpu),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rvalid_o (bus_rvalid),
        .bus_rdata_o  (bus_rdata),
        .irq_o        (irq)
    );

    // {hw, swt, unmask, expected cpu0 event}
    localparam logic [127:0] VEC [0:5] = '{
        {32'h0000_0010, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0001_0004},
        {32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFFF, 32'h0001_0008},
        {32'h8000_0001, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0001_001F},
        {32'h0000_00F0, 32'h0000_0002, 32'hFFFF_FFFF, 32'h0001_0001},
        {32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0010_0000, 32'h0001_0014}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int cpu, input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 4'(cpu);
        bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input int cpu, input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 4'(cpu);
        bus_addr = a; bus_wdata = '0;
        @(negedge clk);
        if (!bus_rvalid) begin
            checks++; errors++;
            $display("FAIL R12: actual rvalid 0 expected 1");
        end
        v = bus_rdata;
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state, R10 / R8 / R11
        #1 check("R11 reset irq", {30'd0, irq}, 32'd0);
        bus_rd(0, 12'h000, r); check("R10 reset mask", r, 32'hFFFF_FFFF);
        bus_rd(0, 12'h800, r); check("R4 reset affinity", r, 32'd1);
        bus_rd(0, 12'h10C, r); check("R10 reset ipi", r, 32'd0);
        bus_rd(0, 12'h100, r); check("R8 empty event", r, 32'd0);

        // Vector table: R1 R2 R3 R6
        for (int k = 0; k < 6; k++) begin
            hw = VEC[k][127:96];
            bus_wr(0, 12'h040, VEC[k][95:64]);
            bus_wr(0, 12'h020, VEC[k][63:32]);
            bus_rd(0, 12'h100, r);
            check($sformatf("R6 R2 R3 vector %0d", k), r, VEC[k][31:0]);
            hw = '0;
            bus_wr(0, 12'h000, 32'hFFFF_FFFF);
            bus_wr(0, 12'h060, 32'hFFFF_FFFF);
        end

        // R5 auto-mask on acknowledge
        hw = 32'h8;
        bus_wr(0, 12'h020, 32'hFFFF_FFFF);
        bus_rd(0, 12'h100, r); check("R5 first read", r, 32'h0001_0003);
        bus_rd(0, 12'h000, r); check("R5 mask set", r, 32'h0000_0008);
        bus_rd(0, 12'h100, r); check("R5 not repeated", r, 32'd0);
        bus_rd(0, 12'h020, r); check("R8 no side effect", r, 32'h0000_0008);
        bus_rd(0, 12'h080, r); check("R10 raw level", r, 32'h0000_0008);

        // R1 level following
        @(negedge clk); hw = 32'h20;
        #1 check("R11 irq on", {30'd0, irq}, 32'd1);
        @(negedge clk); hw = 32'h0;
        #1 check("R1 irq off", {30'd0, irq}, 32'd0);
        bus_rd(0, 12'h100, r); check("R1 no event", r, 32'd0);

        // R3 software trigger
        bus_wr(0, 12'h040, 32'h40);
        #1 check("R3 irq by trigger", {30'd0, irq}, 32'd1);
        bus_rd(0, 12'h100, r); check("R3 trigger event", r, 32'h0001_0006);
        bus_wr(0, 12'h020, 32'h40);
        bus_wr(0, 12'h060, 32'h40);
        bus_rd(0, 12'h100, r); check("R3 cleared", r, 32'd0);
        bus_rd(0, 12'h040, r); check("R10 trigger readback", r, 32'd0);

        // R4 affinity, R9 explicit view
        bus_wr(0, 12'h81C, 32'd2);
        @(negedge clk); hw = 32'h80;
        #1 check("R4 routed to cpu1", {30'd0, irq}, 32'd2);
        bus_rd(0, 12'h100, r); check("R4 cpu0 sees none", r, 32'd0);
        bus_rd(0, 12'h300, r); check("R9 explicit cpu1", r, 32'h0001_0007);
        bus_rd(0, 12'h81C, r); check("R4 affinity readback", r, 32'd2);

        // R9 banked window
        bus_wr(0, 12'h020, 32'h80);
        bus_rd(1, 12'h100, r); check("R9 banked cpu1", r, 32'h0001_0007);

        // R7 IPI precedence and clearing
        bus_wr(0, 12'h020, 32'h80);
        bus_wr(0, 12'h104, 32'h0002_0000);
        bus_rd(0, 12'h30C, r); check("R7 ipi pending", r, 32'd2);
        bus_rd(0, 12'h300, r); check("R7 ipi before hw", r, 32'h0002_0001);
        bus_rd(0, 12'h300, r); check("R7 then hw", r, 32'h0001_0007);
        bus_rd(0, 12'h30C, r); check("R7 ipi cleared", r, 32'd0);
        bus_wr(1, 12'h104, 32'h0000_0003);
        bus_wr(1, 12'h108, 32'h0000_0001);
        bus_rd(1, 12'h10C, r); check("R9 R10 ipi w1c", r, 32'd0);
        bus_rd(0, 12'h20C, r); check("R7 cpu0 slot0", r, 32'd1);
        bus_rd(0, 12'h200, r); check("R7 slot0 event", r, 32'h0002_0000);
        #1 check("R11 all quiet", {30'd0, irq}, 32'd0);
        bus_rd(0, 12'h100, r); check("R8 final empty", r, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule